// File: doc/BRIEF.md
# Six-Queue DMA Transfer Request Arbiter

This block decides which of six DMA queues gets the next host-memory transfer. The queues move data between a network controller and host memory. Each one has an urgent request line and a non-urgent request line. The winner is passed to a single bus interface controller as a registered one-hot grant, together with the queue index and the transfer direction. The grant stays in place until that controller pulses `xfer_done`.

Priority is decided in stages. Any urgent request beats every non-urgent one. Within the same urgency, host-memory writes beat reads, so that write bursts can run back to back. Queues that tie in both urgency and direction take turns through a single rotation pointer.

The controller is a two-state machine:
- `ST_IDLE`: no grant is held. If any request is present, the transition *accept* moves to `ST_HOLD` and registers the grant. With no request present, the machine stays in `ST_IDLE`.
- `ST_HOLD`: the grant is held. On `xfer_done`, the transition *release* returns to `ST_IDLE` and clears the grant.

Queue indices are: 0 receive data, 1 receive status, 2 transmit data, 3 transmit status, 4 receive descriptor, 5 transmit descriptor.

Top module: `dma_queue_arbiter`

## Requirements
- R1: After reset, `grant` is 0, `busy` is 0, `grant_idx` is 0 and `grant_wr` is 0. The rotation pointer starts so that queue 0 is searched first.
- R2: While no request line is asserted in `ST_IDLE`, no grant is issued and `busy` stays low.
- R3: If any urgent (`hard_req`) line is asserted, the granted queue is one whose urgent line was asserted.
- R4: Within one urgency class, write queues 0, 1 and 3 win over read queues 2, 4 and 5.
- R5: A queue that asserts both its urgent and its non-urgent line is treated as urgent.
- R6: Queues tied on urgency and direction are chosen by rotation. The search runs through indices in the cyclic order 0,1,2,3,4,5, starting just after the most recently granted queue. One pointer is shared by all classes.
- R7: `grant` is one-hot. It appears at the clock edge after a request is seen in `ST_IDLE`. While in `ST_HOLD` it stays unchanged, whatever the request lines do, until `xfer_done`.
- R8: `xfer_done` in `ST_HOLD` clears `grant` at the next edge, and arbitration resumes in the following cycle. `xfer_done` in `ST_IDLE` has no effect.
- R9: `grant_idx` is the binary index of the granted queue. `grant_wr` is 1 exactly when that queue is a write queue.
- R10: `busy` is high exactly while a grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hard_req | input | 6 | Urgent request, one bit per queue |
| soft_req | input | 6 | Non-urgent request, one bit per queue |
| xfer_done | input | 1 | Completion pulse from the bus controller |
| grant | output | 6 | Registered one-hot grant |
| grant_idx | output | 3 | Index of the granted queue |
| grant_wr | output | 1 | 1 = host-memory write |
| busy | output | 1 | Grant held |

## Verification
The bench uses the default build: six queues, with the write mask selecting queues 0, 1 and 3. With only 12 request bits, every one of the 4096 urgent/non-urgent combinations can be applied in turn. The rotation pointer carries over from one grant to the next, so the tie-break is exercised from many different starting points across every mix of classes. Each grant is also held while the request lines are inverted, and `xfer_done` is pulsed while idle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_t;

    localparam int NUM_TIERS = 4;
endpackage

// File: rtl/arb_classify.sv
module arb_classify #(
    parameter int              NQ         = 6,
    parameter logic [NQ-1:0]   WRITE_MASK = 6'b001011
) (
    input  logic [NQ-1:0]                       hard_req,
    input  logic [NQ-1:0]                       soft_req,
    output logic [arb_pkg::NUM_TIERS-1:0][NQ-1:0] tiers
);
    logic [NQ-1:0] soft_only;

    // R5: a queue with both lines set counts as urgent only
    assign soft_only = soft_req & ~hard_req;

    // tier order: 0 urgent write, 1 urgent read, 2 normal write, 3 normal read
    always_comb begin
        tiers[0] = hard_req  &  WRITE_MASK;
        tiers[1] = hard_req  & ~WRITE_MASK;
        tiers[2] = soft_only &  WRITE_MASK;
        tiers[3] = soft_only & ~WRITE_MASK;
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NQ = 6,
    localparam int IW = $clog2(NQ)
) (
    input  logic [NQ-1:0] req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    // R6: search begins one place after the last granted queue
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= NQ; k++) begin
            int q;
            q = (int'(last) + k) % NQ;
            if (!found && req[q]) begin
                found = 1'b1;
                idx   = IW'(q);
            end
        end
    end
endmodule

// File: rtl/dma_queue_arbiter.sv
module dma_queue_arbiter #(
    parameter int            NQ         = 6,
    parameter logic [NQ-1:0] WRITE_MASK = 6'b001011,
    localparam int           IW         = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] hard_req,
    input  logic [NQ-1:0] soft_req,
    input  logic          xfer_done,
    output logic [NQ-1:0] grant,
    output logic [IW-1:0] grant_idx,
    output logic          grant_wr,
    output logic          busy
);
    import arb_pkg::*;

    arb_state_t state_q, state_d;

    logic [NUM_TIERS-1:0][NQ-1:0] tiers;
    logic [NUM_TIERS-1:0]         tier_found;
    logic [IW-1:0]                tier_idx [NUM_TIERS];
    logic [IW-1:0]                last_q;
    logic                         win_valid;
    logic [IW-1:0]                win_idx;
    logic                         win_wr;
    logic [NQ-1:0]                grant_q;
    logic [IW-1:0]                idx_q;
    logic                         wr_q;

    arb_classify #(.NQ(NQ), .WRITE_MASK(WRITE_MASK)) u_classify (
        .hard_req (hard_req),
        .soft_req (soft_req),
        .tiers    (tiers)
    );

    for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
        arb_rr_pick #(.NQ(NQ)) u_pick (
            .req   (tiers[t]),
            .last  (last_q),
            .found (tier_found[t]),
            .idx   (tier_idx[t])
        );
    end

    // R3/R4: the lowest-numbered non-empty tier wins
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_wr    = 1'b0;
        for (int t = NUM_TIERS - 1; t >= 0; t--) begin
            if (tier_found[t]) begin
                win_valid = 1'b1;
                win_idx   = tier_idx[t];
                win_wr    = (t % 2) == 0;
            end
        end
    end

    // next-state logic: accept and release transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_valid) state_d = ST_HOLD;
            ST_HOLD: if (xfer_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            last_q  <= IW'(NQ - 1);
        end else if (state_q == ST_IDLE && win_valid) begin
            grant_q <= NQ'(1) << win_idx;
            idx_q   <= win_idx;
            wr_q    <= win_wr;
            last_q  <= win_idx;
        end else if (state_q == ST_HOLD && xfer_done) begin
            grant_q <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
        end
    end

    assign grant     = grant_q;
    assign grant_idx = idx_q;
    assign grant_wr  = wr_q;
    assign busy      = (state_q == ST_HOLD);

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> $stable(grant));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done) |=> (grant == '0));
    assert_busy_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (grant != '0));
    assert_idle_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hard_req == '0 && soft_req == '0) |=> !busy);
    assert_hard_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(hard_req) != '0) |-> ((grant & $past(hard_req)) != '0));
    assert_write_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && ($past(hard_req) & WRITE_MASK) != '0) |-> grant_wr);
    assert_dir_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (grant_wr == ((grant & WRITE_MASK) != '0)));
endmodule

// File: tb/dma_queue_arbiter_bench.sv
module dma_queue_arbiter_bench;
    localparam logic [5:0] WMASK = 6'b001011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] hard_req = '0;
    logic [5:0] soft_req = '0;
    logic       xfer_done = 1'b0;
    logic [5:0] grant;
    logic [2:0] grant_idx;
    logic       grant_wr;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_queue_arbiter u_dma_queue_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .hard_req  (hard_req),
        .soft_req  (soft_req),
        .xfer_done (xfer_done),
        .grant     (grant),
        .grant_idx (grant_idx),
        .grant_wr  (grant_wr),
        .busy      (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected winner from the requirements: tiers, then rotation
    function automatic int expect_idx(input logic [5:0] h, input logic [5:0] s, input int last);
        logic [5:0] tier [4];
        tier[0] = h & WMASK;
        tier[1] = h & ~WMASK;
        tier[2] = s & ~h & WMASK;
        tier[3] = s & ~h & ~WMASK;
        for (int t = 0; t < 4; t++) begin
            if (tier[t] != 0) begin
                for (int k = 1; k <= 6; k++) begin
                    int q = (last + k) % 6;
                    if (tier[t][q]) return q;
                end
            end
        end
        return -1;
    endfunction

    initial begin
        int last = 5;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 grant", int'(grant), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 grant_idx", int'(grant_idx), 0);
        check("R1 grant_wr", int'(grant_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle no grant", int'(busy), 0);
        for (int p = 0; p < 4096; p++) begin
            logic [5:0] h = p[11:6];
            logic [5:0] s = p[5:0];
            int e = expect_idx(h, s, last);
            hard_req = h;
            soft_req = s;
            xfer_done = 1'b0;
            @(negedge clk);
            if (e < 0) begin
                check("R2 no grant", int'(grant), 0);
                check("R2 busy low", int'(busy), 0);
                xfer_done = 1'b1;
                @(negedge clk);
                check("R8 done ignored in idle", int'(grant), 0);
                check("R10 busy idle", int'(busy), 0);
                xfer_done = 1'b0;
            end else begin
                // R3 R4 R5 R6 winner, R9 encoding
                check("R3/R4/R5/R6 grant", int'(grant), 1 << e);
                check("R9 grant_idx", int'(grant_idx), e);
                check("R9 grant_wr", int'(grant_wr), int'(WMASK[e]));
                check("R10 busy held", int'(busy), 1);
                hard_req = ~h;
                soft_req = ~s;
                @(negedge clk);
                check("R7 grant stable", int'(grant), 1 << e);
                check("R7 idx stable", int'(grant_idx), e);
                hard_req = '0;
                soft_req = '0;
                xfer_done = 1'b1;
                @(negedge clk);
                check("R8 release grant", int'(grant), 0);
                check("R10 busy released", int'(busy), 0);
                xfer_done = 1'b0;
                last = e;
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule